// File: doc/BRIEF.md
# Carry-Policy Decoded ALU

A 32-bit arithmetic-logic unit that keeps a carry flag between operations. Every opcode is decoded into a small configuration with four parts. The first is the base function: add, OR, AND or XOR. The second is where the adder's carry input comes from. The third is whether operand B is inverted. The fourth is how the carry flag is updated once the operation completes. A single adder therefore serves signed, unsigned, flag-free and bounds-check arithmetic. The difference between these classes lies only in how each one reads and writes the flag.

The result, the raw adder carry-out, the signed overflow indication and the bounds violation are combinational from the operands and the opcode. The stored flag changes on the rising clock edge, and only when the enable input is high. Multi-word arithmetic chains unsigned adds or subtracts through the flag. A bounds check compares two values without disturbing the flag.

Top module: `carry_alu`

## Requirements
- R1: While rst_ni is low, and after it is released, carry_o reads 0 until the first enabled operation that writes the flag.
- R2: The carry flag changes only on a rising clock edge with en_i high. With en_i low, carry_o holds whatever the opcode.
- R3: Signed add (op 0) yields A+B+flag. Signed subtract (op 1) yields A+~B+~flag. Both clear the flag.
- R4: Unsigned add (op 2) yields A+B+flag and stores the adder carry-out in the flag. Unsigned subtract (op 3) yields A+~B+~flag and stores the inverted carry-out, which is the borrow.
- R5: The flag-free adds (ops 4 and 6) yield A+B with carry-in 0. The flag-free subtract (op 5) yields A-B, which is A+~B+1. All three leave the flag unchanged.
- R6: Plain add (op 8) yields A+B with carry-in 0. Plain subtract (op 9) yields A-B. Both clear the flag.
- R7: Bounds check (op 7) yields A-B and leaves the flag unchanged. bound_viol_o is 1 exactly when op 7 is applied with A >= B unsigned. It is 0 for every other opcode.
- R8: OR (op 10), AND (op 11) and XOR (op 12) return the bitwise result. The spare opcode 13 and the undefined codes 14 and 15 behave as OR. All of these keep the flag, and they drive cout_o and ovf_o to 0.
- R9: For add-type opcodes (0 to 9), ovf_o is 1 when the sign of the result differs from the common sign of A and the effective B. The effective B is B after any inversion.
- R10: For add-type opcodes, cout_o is bit 32 of A + effective B + carry-in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Enable; lets the flag update on the clock edge |
| op_i | input | 4 | Opcode |
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B |
| result_o | output | 32 | Operation result |
| cout_o | output | 1 | Raw adder carry-out, 0 for logic ops |
| ovf_o | output | 1 | Signed overflow, 0 for logic ops |
| carry_o | output | 1 | Stored carry flag |
| bound_viol_o | output | 1 | Bounds-check violation, A >= B unsigned |

## Verification
The assertions assume that op_i, en_i and the operands are stable and known around each rising clock edge. Flag properties compare the value after an edge with the cout_o sampled at that edge, so they rely on the inputs not changing in the same time step as the clock. The bench meets this by changing every input half a cycle away from the active edge and holding it through the next edge. It also releases reset away from any edge.

// File: rtl/carry_alu_pkg.sv
package carry_alu_pkg;
  localparam int unsigned OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_SADD  = 4'd0,
    OP_SSUB  = 4'd1,
    OP_UADD  = 4'd2,
    OP_USUB  = 4'd3,
    OP_NADD  = 4'd4,
    OP_NSUB  = 4'd5,
    OP_NADD2 = 4'd6,
    OP_BCHK  = 4'd7,
    OP_LADD  = 4'd8,
    OP_LSUB  = 4'd9,
    OP_OR    = 4'd10,
    OP_AND   = 4'd11,
    OP_XOR   = 4'd12,
    OP_SPARE = 4'd13
  } op_e;

  typedef enum logic [1:0] {BASE_ADD, BASE_OR, BASE_AND, BASE_XOR} base_e;
  typedef enum logic [1:0] {CIN_FLAG, CIN_NFLAG, CIN_ZERO, CIN_ONE} cin_e;
  typedef enum logic [1:0] {POL_CLEAR, POL_KEEP, POL_STORE, POL_STORE_INV} pol_e;

  typedef struct packed {
    base_e base;
    cin_e  cin;
    pol_e  pol;
    logic  inv_b;
  } cfg_t;
endpackage

// File: rtl/carry_alu_decode.sv
module carry_alu_decode
  import carry_alu_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output cfg_t            cfg_o
);
  always_comb begin
    unique case (op_i)
      OP_SADD:  cfg_o = '{BASE_ADD, CIN_FLAG,  POL_CLEAR,     1'b0};
      OP_SSUB:  cfg_o = '{BASE_ADD, CIN_NFLAG, POL_CLEAR,     1'b1};
      OP_UADD:  cfg_o = '{BASE_ADD, CIN_FLAG,  POL_STORE,     1'b0};
      OP_USUB:  cfg_o = '{BASE_ADD, CIN_NFLAG, POL_STORE_INV, 1'b1};
      OP_NADD,
      OP_NADD2: cfg_o = '{BASE_ADD, CIN_ZERO,  POL_KEEP,      1'b0};
      OP_NSUB,
      OP_BCHK:  cfg_o = '{BASE_ADD, CIN_ONE,   POL_KEEP,      1'b1};
      OP_LADD:  cfg_o = '{BASE_ADD, CIN_ZERO,  POL_CLEAR,     1'b0};
      OP_LSUB:  cfg_o = '{BASE_ADD, CIN_ONE,   POL_CLEAR,     1'b1};
      OP_AND:   cfg_o = '{BASE_AND, CIN_ZERO,  POL_KEEP,      1'b0};
      OP_XOR:   cfg_o = '{BASE_XOR, CIN_ZERO,  POL_KEEP,      1'b0};
      default:  cfg_o = '{BASE_OR,  CIN_ZERO,  POL_KEEP,      1'b0}; // spare and undefined
    endcase
  end
endmodule

// File: rtl/carry_alu_datapath.sv
module carry_alu_datapath
  import carry_alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  cfg_t             cfg_i,
  input  logic             flag_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] result_o,
  output logic             cout_o,
  output logic             ovf_o
);
  localparam int unsigned LW = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;
  logic             cin;
  logic [WIDTH-1:0] low_sum;  // LW sum bits plus carry into the MSB
  logic [1:0]       top_sum;
  logic [WIDTH-1:0] add_res;
  logic             is_add;

  assign b_eff = cfg_i.inv_b ? ~b_i : b_i;

  always_comb begin
    unique case (cfg_i.cin)
      CIN_FLAG:  cin = flag_i;
      CIN_NFLAG: cin = ~flag_i;
      CIN_ZERO:  cin = 1'b0;
      default:   cin = 1'b1;
    endcase
  end

  assign low_sum = {1'b0, a_i[LW-1:0]} + {1'b0, b_eff[LW-1:0]} + {{LW{1'b0}}, cin};
  assign top_sum = {1'b0, a_i[LW]} + {1'b0, b_eff[LW]} + {1'b0, low_sum[LW]};
  assign add_res = {top_sum[0], low_sum[LW-1:0]};
  assign is_add  = (cfg_i.base == BASE_ADD);

  always_comb begin
    unique case (cfg_i.base)
      BASE_ADD: result_o = add_res;
      BASE_AND: result_o = a_i & b_i;
      BASE_XOR: result_o = a_i ^ b_i;
      default:  result_o = a_i | b_i;
    endcase
  end

  assign cout_o = is_add & top_sum[1];
  assign ovf_o  = is_add & (top_sum[1] ^ low_sum[LW]);
endmodule

// File: rtl/carry_alu_flag.sv
module carry_alu_flag
  import carry_alu_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  pol_e pol_i,
  input  logic cout_i,
  output logic flag_o
);
  logic flag_d;

  always_comb begin
    unique case (pol_i)
      POL_CLEAR:     flag_d = 1'b0;
      POL_STORE:     flag_d = cout_i;
      POL_STORE_INV: flag_d = ~cout_i;
      default:       flag_d = flag_o;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   flag_o <= 1'b0;
    else if (en_i) flag_o <= flag_d;
  end
endmodule

// File: rtl/carry_alu.sv
module carry_alu
  import carry_alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [OP_W-1:0]  op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] result_o,
  output logic             cout_o,
  output logic             ovf_o,
  output logic             carry_o,
  output logic             bound_viol_o
);
  cfg_t cfg;
  logic flag;

  carry_alu_decode u_dec (
    .op_i  (op_i),
    .cfg_o (cfg)
  );

  carry_alu_datapath #(.WIDTH(WIDTH)) u_dp (
    .cfg_i    (cfg),
    .flag_i   (flag),
    .a_i      (a_i),
    .b_i      (b_i),
    .result_o (result_o),
    .cout_o   (cout_o),
    .ovf_o    (ovf_o)
  );

  carry_alu_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .pol_i  (cfg.pol),
    .cout_i (cout_o),
    .flag_o (flag)
  );

  assign carry_o      = flag;
  // A - B carries out exactly when A >= B unsigned
  assign bound_viol_o = (op_i == OP_BCHK) & cout_o;
endmodule

// File: rtl/carry_alu_chk.sv
module carry_alu_chk
  import carry_alu_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            en_i,
  input logic [OP_W-1:0] op_i,
  input logic            cout_o,
  input logic            ovf_o,
  input logic            carry_o,
  input logic            bound_viol_o
);
  AST_RESET_FLAG: assert property (@(posedge clk_i) !rst_ni |-> !carry_o); // R1

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(carry_o)); // R2

  AST_FLAG_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && (op_i == OP_SADD || op_i == OP_SSUB || op_i == OP_LADD || op_i == OP_LSUB)
    |=> !carry_o); // R3

  AST_UADD_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && op_i == OP_UADD |=> carry_o == $past(cout_o)); // R4

  AST_USUB_BORROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && op_i == OP_USUB |=> carry_o == !$past(cout_o)); // R4

  AST_NOFLAG_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && (op_i == OP_NADD || op_i == OP_NSUB || op_i == OP_NADD2 || op_i == OP_BCHK)
    |=> $stable(carry_o)); // R5

  AST_VIOL_ONLY_BCHK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bound_viol_o |-> op_i == OP_BCHK); // R7

  AST_LOGIC_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i >= OP_OR |-> !cout_o && !ovf_o); // R8

  AST_LOGIC_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && op_i >= OP_OR |=> $stable(carry_o)); // R8
endmodule

bind carry_alu carry_alu_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .en_i         (en_i),
  .op_i         (op_i),
  .cout_o       (cout_o),
  .ovf_o        (ovf_o),
  .carry_o      (carry_o),
  .bound_viol_o (bound_viol_o)
);

// File: tb/carry_alu_tb_top.sv
module carry_alu_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic [3:0]  op_i = 4'd0;
  logic [31:0] a_i = '0;
  logic [31:0] b_i = '0;
  logic [31:0] result_o;
  logic        cout_o, ovf_o, carry_o, bound_viol_o;

  int checks = 0;
  int errors = 0;
  logic model_flag = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  carry_alu dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .op_i(op_i),
    .a_i(a_i), .b_i(b_i), .result_o(result_o), .cout_o(cout_o),
    .ovf_o(ovf_o), .carry_o(carry_o), .bound_viol_o(bound_viol_o)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Drive one operation, check combinational outputs, then the flag after the edge
  task automatic run_op(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                        input logic en, input string req);
    logic        is_add, inv, cin, nf;
    logic [31:0] be, exp_res;
    logic [32:0] s;
    logic        exp_c, exp_v, exp_viol;
    is_add = (op <= 4'd9);
    inv = (op == 4'd1 || op == 4'd3 || op == 4'd5 || op == 4'd7 || op == 4'd9);
    case (op)
      4'd0, 4'd2: cin = model_flag;
      4'd1, 4'd3: cin = ~model_flag;
      4'd5, 4'd7, 4'd9: cin = 1'b1;
      default: cin = 1'b0;
    endcase
    be = inv ? ~b : b;
    s = {1'b0, a} + {1'b0, be} + {32'd0, cin};
    case (op)
      4'd11: exp_res = a & b;
      4'd12: exp_res = a ^ b;
      default: exp_res = is_add ? s[31:0] : (a | b);
    endcase
    exp_c = is_add & s[32];
    exp_v = is_add & (a[31] == be[31]) & (s[31] != a[31]);
    exp_viol = (op == 4'd7) & (a >= b);
    case (op)
      4'd0, 4'd1, 4'd8, 4'd9: nf = 1'b0;
      4'd2: nf = s[32];
      4'd3: nf = ~s[32];
      default: nf = model_flag;
    endcase
    if (!en) nf = model_flag;
    @(negedge clk_i);
    op_i = op; a_i = a; b_i = b; en_i = en;
    #1;
    chk(req, "result", result_o, exp_res);
    chk(req, "cout", {31'd0, cout_o}, {31'd0, exp_c});
    chk(req, "ovf", {31'd0, ovf_o}, {31'd0, exp_v});
    chk(req, "viol", {31'd0, bound_viol_o}, {31'd0, exp_viol});
    @(posedge clk_i);
    #1;
    model_flag = nf;
    chk(req, "flag", {31'd0, carry_o}, {31'd0, model_flag});
    en_i = 1'b0;
  endtask

  task automatic test_reset;
    #3;
    chk("R1", "flag in reset", {31'd0, carry_o}, 32'd0);
    repeat (2) @(posedge clk_i);
    #2 rst_ni = 1'b1;
    @(posedge clk_i); #1;
    chk("R1", "flag after reset", {31'd0, carry_o}, 32'd0);
  endtask

  task automatic test_unsigned;
    run_op(4'd2, 32'hFFFF_FFFF, 32'h0000_0001, 1'b1, "R4"); // carry set
    run_op(4'd2, 32'h0000_0010, 32'h0000_0020, 1'b1, "R4"); // adds flag in, carry clear
    run_op(4'd3, 32'h0000_0001, 32'h0000_0002, 1'b1, "R4"); // borrow set
    run_op(4'd3, 32'h0000_0010, 32'h0000_0005, 1'b1, "R4"); // borrow consumed
    run_op(4'd3, 32'h0000_0005, 32'h0000_0005, 1'b1, "R4");
  endtask

  task automatic test_signed;
    run_op(4'd2, 32'hFFFF_FFFF, 32'h0000_0003, 1'b1, "R3"); // set flag first
    run_op(4'd0, 32'h0000_0004, 32'h0000_0005, 1'b1, "R3"); // uses flag, clears
    run_op(4'd3, 32'h0000_0000, 32'h0000_0001, 1'b1, "R3"); // borrow=1
    run_op(4'd1, 32'h0000_0009, 32'h0000_0003, 1'b1, "R3"); // uses ~flag, clears
    run_op(4'd1, 32'h0000_0009, 32'h0000_0003, 1'b1, "R3");
  endtask

  task automatic test_noflag;
    run_op(4'd2, 32'h8000_0000, 32'h8000_0000, 1'b1, "R5"); // flag=1
    run_op(4'd4, 32'hFFFF_FFFF, 32'h0000_0001, 1'b1, "R5");
    run_op(4'd6, 32'h1234_5678, 32'h1111_1111, 1'b1, "R5");
    run_op(4'd5, 32'h0000_0003, 32'h0000_0007, 1'b1, "R5");
    run_op(4'd5, 32'h0000_0007, 32'h0000_0003, 1'b1, "R5");
  endtask

  task automatic test_plain;
    run_op(4'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R6"); // flag=1
    run_op(4'd8, 32'h0000_0001, 32'h0000_0002, 1'b1, "R6");
    run_op(4'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R6");
    run_op(4'd9, 32'h0000_0002, 32'h0000_0005, 1'b1, "R6");
  endtask

  task automatic test_bounds;
    run_op(4'd7, 32'h0000_0005, 32'h0000_0005, 1'b1, "R7"); // equal -> violation
    run_op(4'd7, 32'h0000_0004, 32'h0000_0005, 1'b1, "R7"); // below -> ok
    run_op(4'd7, 32'h8000_0000, 32'h7FFF_FFFF, 1'b1, "R7"); // unsigned compare
    run_op(4'd5, 32'h0000_0009, 32'h0000_0001, 1'b1, "R7"); // not bounds op
  endtask

  task automatic test_logic;
    run_op(4'd10, 32'hF0F0_0000, 32'h0F0F_00FF, 1'b1, "R8");
    run_op(4'd11, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R8");
    run_op(4'd12, 32'hAAAA_5555, 32'hFFFF_0000, 1'b1, "R8");
    run_op(4'd13, 32'h1200_0034, 32'h0056_7800, 1'b1, "R8");
    run_op(4'd14, 32'h8000_0000, 32'h8000_0001, 1'b1, "R8");
    run_op(4'd15, 32'h0000_00F0, 32'h0000_000F, 1'b1, "R8");
  endtask

  task automatic test_overflow;
    run_op(4'd8, 32'h7FFF_FFFF, 32'h0000_0001, 1'b1, "R9");  // pos overflow
    run_op(4'd8, 32'h8000_0000, 32'h8000_0000, 1'b1, "R9");  // neg overflow, carry
    run_op(4'd9, 32'h8000_0000, 32'h0000_0001, 1'b1, "R9");  // sub overflow
    run_op(4'd9, 32'h0000_0000, 32'h0000_0000, 1'b1, "R10"); // carry out on 0-0
    run_op(4'd4, 32'h4000_0000, 32'hC000_0000, 1'b1, "R10");
  endtask

  task automatic test_enable;
    run_op(4'd2, 32'hFFFF_FFFF, 32'h0000_0001, 1'b0, "R2"); // would set flag
    run_op(4'd2, 32'hFFFF_FFFF, 32'h0000_0001, 1'b1, "R2");
    run_op(4'd0, 32'h0000_0001, 32'h0000_0001, 1'b0, "R2"); // would clear
    run_op(4'd3, 32'h0000_0009, 32'h0000_0001, 1'b0, "R2");
    run_op(4'd8, 32'h0000_0001, 32'h0000_0001, 1'b1, "R2");
  endtask

  initial begin
    test_reset();
    test_unsigned();
    test_signed();
    test_noflag();
    test_plain();
    test_bounds();
    test_logic();
    test_overflow();
    test_enable();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule